// File: doc/BRIEF.md
# Three-Channel Programmable Timer Unit

This block is a register-mapped timer with three independent counting channels and a shared interrupt section. A host reaches it through a plain 32-bit bus: one write strobe with address and data, and a combinational read port. Each channel has four registers: a control word, a command word, a reload value and a read-only live count. The control word selects the count direction, one-shot or free-running operation and 16- or 32-bit counting. The command word carries one-cycle strobes: start, stop and load-from-reload. Writing start and load together restarts a channel from its reload value in a single bus write.

When a channel reaches its terminal count it reloads itself and raises a pending flag. In one-shot mode it also halts. Pending flags sit at even bit positions: channel n uses bit 2n. Each flag is masked by an enable register and cleared by writing a one to it. Each channel drives its own interrupt line.

A global clock-control word can freeze every counter and suppress new events while the bus stays fully usable. A read-only identification word reports a version, a configuration code equal to the channel count, and a module identifier.

Top module: `gp_timer_unit`

## Requirements
- R1: After reset every control, reload, count, enable, pending and clock-control register reads 0, all channels are stopped and every `irq_o` bit is low.
- R2: Channel n's registers sit at byte addresses 0x10+n*0x20 (control), 0x18+n*0x20 (command), 0x20+n*0x20 (reload) and 0x28+n*0x20 (live count, read-only). The identification word at 0x08 reads {16'h0, module id 8'h5A, configuration 3'd3, version 5'd2} = 0x00005A62, and writes to it are ignored.
- R3: Control bit 0 reads 1 while the channel runs and ignores writes. Bits 8:1 are stored and read back, with bit 1 = count up, bit 3 = one-shot and bit 4 = 32-bit width. The command register always reads 0.
- R4: A command write acts on bit 0 (start), bit 1 (stop) and bit 2 (load the counter from reload). Stop beats start in the same write. Start together with load sets the count to the reload value and starts counting on the following cycle.
- R5: Counting down, the tick that would bring the count to zero, or a tick taken at zero, raises the terminal event and loads the reload value instead. A reload value N therefore gives one event every N cycles.
- R6: Counting up, the tick taken at all-ones raises the event and reloads. All-ones means 0xFFFF with bit 4 clear and 0xFFFFFFFF with bit 4 set; in 16-bit mode the count never exceeds 0xFFFF.
- R7: In one-shot mode the terminal event stops the channel, leaving the count at the reload value and control bit 0 cleared.
- R8: In continuous mode the channel keeps running after each terminal event and repeats the same period.
- R9: A terminal event on channel n sets pending bit 2n. Writing 1 to bit 2n at 0xFC clears it and writing 0 leaves it set. An event in the same cycle as a clear leaves the bit set.
- R10: `irq_o[n]` is high exactly while pending bit 2n and enable bit 2n (register 0xF4) are both set. 0xF8 reads the unmasked pending bits and 0xFC reads pending AND enable.
- R11: While clock-control (0x00) bit 0 is set, no counter changes and no event is raised. Bits 0, 4, 8 and 16 of clock-control are stored and read back, and all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 3 | Per-channel interrupt, bit n for channel n |

## Verification
The bench lands a pending-clear write on the exact cycle of a terminal event. A design that lets the clear win would silently lose a tick. It also measures the down-count period edge by edge, so a design that counts down to zero before reloading would be one cycle slow.

An up-counter loaded near 0xFFFF is run in both widths. A design that ignores the width bit either wraps into bit 16 or fires early. The bench also writes start and stop together, and expects the channel to stay stopped. Finally, clock-control is toggled in the middle of a count: a design that still ticks while frozen, or raises events while frozen, shows a changed count or a stray pending bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int REG_W = 32;

  // Count limit for the selected width.
  function automatic logic [REG_W-1:0] width_mask(input logic wide);
    return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  // Terminal condition for one tick from the current count.
  function automatic logic at_terminal(input logic [REG_W-1:0] cnt,
                                       input logic up, input logic wide);
    logic [REG_W-1:0] m;
    m = width_mask(wide);
    if (up) return (cnt & m) == m;
    return (cnt & m) <= 32'd1;
  endfunction

  // Count after one ordinary (non-terminal) tick.
  function automatic logic [REG_W-1:0] step_count(input logic [REG_W-1:0] cnt,
                                                  input logic up, input logic wide);
    return (up ? cnt + 32'd1 : cnt - 32'd1) & width_mask(wide);
  endfunction
endpackage

// File: rtl/tmr_channel.sv
module tmr_channel
  import tmr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr_i,
  input  logic [8:1]       ctrl_wdata_i,
  input  logic             reload_wr_i,
  input  logic [REG_W-1:0] reload_wdata_i,
  input  logic             cmd_start_i,
  input  logic             cmd_stop_i,
  input  logic             cmd_load_i,
  input  logic             freeze_i,
  output logic [REG_W-1:0] ctrl_rd_o,
  output logic [REG_W-1:0] reload_o,
  output logic [REG_W-1:0] count_o,
  output logic             event_o
);
  logic [8:1]       ctrl_q;
  logic [REG_W-1:0] reload_q, cnt_q;
  logic             running_q;
  logic             mode_up, mode_oneshot, mode_wide;
  logic             tick, terminal;

  assign mode_up      = ctrl_q[1];
  assign mode_oneshot = ctrl_q[3];
  assign mode_wide    = ctrl_q[4];

  assign tick     = running_q && !freeze_i && !cmd_load_i;
  assign terminal = at_terminal(cnt_q, mode_up, mode_wide);
  assign event_o  = tick && terminal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      reload_q  <= '0;
      cnt_q     <= '0;
      running_q <= 1'b0;
    end else begin
      if (ctrl_wr_i)   ctrl_q   <= ctrl_wdata_i;
      if (reload_wr_i) reload_q <= reload_wdata_i;
      if (cmd_stop_i)                       running_q <= 1'b0;
      else if (cmd_start_i)                 running_q <= 1'b1;
      else if (event_o && mode_oneshot)     running_q <= 1'b0;
      if (cmd_load_i)   cnt_q <= reload_q & width_mask(mode_wide);
      else if (event_o) cnt_q <= reload_q & width_mask(mode_wide);
      else if (tick)    cnt_q <= step_count(cnt_q, mode_up, mode_wide);
    end
  end

  assign ctrl_rd_o = {23'd0, ctrl_q, running_q};
  assign reload_o  = reload_q;
  assign count_o   = cnt_q;

  // R4: stop wins over a simultaneous start
  assert_stop_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_stop_i |=> !running_q);
  // R11: a frozen channel keeps its count unless explicitly loaded
  assert_freeze_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze_i && !cmd_load_i) |=> $stable(cnt_q));
  // R7: one-shot terminal event halts the channel
  assert_oneshot_halt_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (event_o && mode_oneshot && !cmd_start_i) |=> !running_q);
  // R11: no events while frozen
  assert_no_event_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_i |-> !event_o);
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq #(
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] event_i,
  input  logic              en_wr_i,
  input  logic              clr_wr_i,
  input  logic [NUM_CH-1:0] wdata_even_i,
  output logic [31:0]       enable_o,
  output logic [31:0]       raw_o,
  output logic [31:0]       masked_o,
  output logic [NUM_CH-1:0] irq_o
);
  logic [NUM_CH-1:0] en_q, pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (en_wr_i) en_q <= wdata_even_i;
      pend_q <= event_i | (pend_q & ~(clr_wr_i ? wdata_even_i : '0));
    end
  end

  always_comb begin
    enable_o = '0;
    raw_o    = '0;
    masked_o = '0;
    for (int n = 0; n < NUM_CH; n++) begin
      enable_o[2*n] = en_q[n];
      raw_o[2*n]    = pend_q[n];
      masked_o[2*n] = pend_q[n] & en_q[n];
    end
  end

  assign irq_o = pend_q & en_q;

  for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
    // R9: an event always leaves its pending bit set, even against a clear
    assert_event_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      event_i[n] |=> pend_q[n]);
    // R9: a clear without a competing event removes the bit
    assert_clear_works_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_wr_i && wdata_even_i[n] && !event_i[n]) |=> !pend_q[n]);
    // R10: an interrupt only rises with its enable set
    assert_irq_enabled_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o[n]) |-> en_q[n]);
  end
endmodule

// File: rtl/gp_timer_unit.sv
module gp_timer_unit
  import tmr_pkg::*;
#(
  parameter int          NUM_CH  = 3,
  parameter int          ADDR_W  = 8,
  parameter logic [4:0]  VERSION = 5'd2,
  parameter logic [7:0]  MOD_ID  = 8'h5A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq_o
);
  localparam logic [ADDR_W-1:0] A_CLK  = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(8'hF4);
  localparam logic [ADDR_W-1:0] A_RAW  = ADDR_W'(8'hF8);
  localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(8'hFC);
  localparam logic [31:0] CLK_KEEP = 32'h0001_0111;
  localparam logic [31:0] ID_WORD  = {16'd0, MOD_ID, 3'(NUM_CH), VERSION};

  function automatic logic [ADDR_W-1:0] ch_addr(input int n, input int sub);
    return ADDR_W'(32'h10 + n * 32'h20 + sub);
  endfunction

  logic [31:0]       clk_ctrl_q;
  logic [31:0]       ch_ctrl_rd [NUM_CH];
  logic [31:0]       ch_reload  [NUM_CH];
  logic [31:0]       ch_count   [NUM_CH];
  logic [NUM_CH-1:0] ch_event;
  logic [NUM_CH-1:0] wdata_even;
  logic [31:0]       en_rd, raw_rd, masked_rd;
  logic              freeze;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_ctrl_q <= '0;
    else if (bus_wr && bus_addr == A_CLK) clk_ctrl_q <= bus_wdata & CLK_KEEP;
  end
  assign freeze = clk_ctrl_q[0];

  always_comb begin
    for (int n = 0; n < NUM_CH; n++) wdata_even[n] = bus_wdata[2*n];
  end

  for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
    logic run_wr;
    assign run_wr = bus_wr && bus_addr == ch_addr(n, 8);
    tmr_channel i_chan (
      .clk            (clk),
      .rst_n          (rst_n),
      .ctrl_wr_i      (bus_wr && bus_addr == ch_addr(n, 0)),
      .ctrl_wdata_i   (bus_wdata[8:1]),
      .reload_wr_i    (bus_wr && bus_addr == ch_addr(n, 16)),
      .reload_wdata_i (bus_wdata),
      .cmd_start_i    (run_wr && bus_wdata[0]),
      .cmd_stop_i     (run_wr && bus_wdata[1]),
      .cmd_load_i     (run_wr && bus_wdata[2]),
      .freeze_i       (freeze),
      .ctrl_rd_o      (ch_ctrl_rd[n]),
      .reload_o       (ch_reload[n]),
      .count_o        (ch_count[n]),
      .event_o        (ch_event[n])
    );
  end

  tmr_irq #(.NUM_CH(NUM_CH)) i_irq (
    .clk          (clk),
    .rst_n        (rst_n),
    .event_i      (ch_event),
    .en_wr_i      (bus_wr && bus_addr == A_EN),
    .clr_wr_i     (bus_wr && bus_addr == A_PEND),
    .wdata_even_i (wdata_even),
    .enable_o     (en_rd),
    .raw_o        (raw_rd),
    .masked_o     (masked_rd),
    .irq_o        (irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      A_CLK:   bus_rdata = clk_ctrl_q;
      A_ID:    bus_rdata = ID_WORD;
      A_EN:    bus_rdata = en_rd;
      A_RAW:   bus_rdata = raw_rd;
      A_PEND:  bus_rdata = masked_rd;
      default: bus_rdata = '0;
    endcase
    for (int n = 0; n < NUM_CH; n++) begin
      if (bus_addr == ch_addr(n, 0))  bus_rdata = ch_ctrl_rd[n];
      if (bus_addr == ch_addr(n, 16)) bus_rdata = ch_reload[n];
      if (bus_addr == ch_addr(n, 24)) bus_rdata = ch_count[n];
    end
  end

  // R11: only the defined clock-control bits ever hold a one
  assert_clk_bits_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_ctrl_q & ~CLK_KEEP) == 32'd0);
endmodule

// File: tb/test_gp_timer_unit.sv
module test_gp_timer_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq_o;
  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gp_timer_unit i_gp_timer_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  // channel register addresses
  function automatic logic [7:0] a_ctl(int n);  return 8'(16 + 32*n); endfunction
  function automatic logic [7:0] a_run(int n);  return 8'(24 + 32*n); endfunction
  function automatic logic [7:0] a_rld(int n);  return 8'(32 + 32*n); endfunction
  function automatic logic [7:0] a_cnt(int n);  return 8'(40 + 32*n); endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  task automatic edges(int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic expect_rd(string tag, logic [7:0] a, logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    check("R1 irq low", {29'd0, irq_o}, 32'd0);
    expect_rd("R1 clock-control", 8'h00, 0);
    expect_rd("R1 enable", 8'hF4, 0);
    expect_rd("R1 raw pending", 8'hF8, 0);
    for (int n = 0; n < 3; n++) begin
      expect_rd("R1 control", a_ctl(n), 0);
      expect_rd("R1 count", a_cnt(n), 0);
    end
    expect_rd("R2 id word", 8'h08, 32'h0000_5A62);
    wr(8'h08, 32'hFFFF_FFFF);
    expect_rd("R2 id ignores writes", 8'h08, 32'h0000_5A62);
  endtask

  task automatic t_down_continuous;
    wr(a_ctl(0), 32'h0);
    wr(a_rld(0), 32'd5);
    expect_rd("R2 reload readback", a_rld(0), 32'd5);
    wr(a_run(0), 32'h5);
    expect_rd("R4 start+load count", a_cnt(0), 32'd5);
    expect_rd("R3 command reads zero", a_run(0), 32'd0);
    expect_rd("R3 running flag", a_ctl(0), 32'h1);
    edges(4);
    expect_rd("R5 count before terminal", a_cnt(0), 32'd1);
    expect_rd("R5 no early event", 8'hF8, 32'd0);
    edges(1);
    expect_rd("R5 event after N cycles", 8'hF8, 32'h1);
    expect_rd("R5 reload on terminal", a_cnt(0), 32'd5);
    wr(8'hFC, 32'h1);
    expect_rd("R9 clear pending", 8'hF8, 32'd0);
    expect_rd("R8 still counting", a_cnt(0), 32'd4);
    edges(3);
    wr(8'hFC, 32'h1);
    expect_rd("R9 event beats clear", 8'hF8, 32'h1);
    expect_rd("R8 second period", a_cnt(0), 32'd5);
    wr(a_run(0), 32'h2);
    edges(3);
    expect_rd("R4 stop holds count", a_cnt(0), 32'd4);
    expect_rd("R3 running flag clear", a_ctl(0), 32'h0);
  endtask

  task automatic t_irq;
    check("R10 masked irq low", {29'd0, irq_o}, 32'd0);
    expect_rd("R10 masked view zero", 8'hFC, 32'd0);
    wr(8'hF4, 32'h1);
    check("R10 irq high", {29'd0, irq_o}, 32'd1);
    expect_rd("R10 masked view", 8'hFC, 32'h1);
    wr(8'hFC, 32'h0);
    expect_rd("R9 write zero keeps", 8'hF8, 32'h1);
    wr(8'hFC, 32'h1);
    check("R10 irq cleared", {29'd0, irq_o}, 32'd0);
    wr(8'hF4, 32'h0);
  endtask

  task automatic t_up;
    wr(a_ctl(1), 32'h2);
    wr(a_rld(1), 32'h0000_FFFD);
    wr(a_run(1), 32'h5);
    edges(2);
    expect_rd("R6 16-bit at top", a_cnt(1), 32'h0000_FFFF);
    expect_rd("R6 no event yet", 8'hF8, 32'd0);
    edges(1);
    expect_rd("R6 16-bit wrap event bit2", 8'hF8, 32'h4);
    expect_rd("R6 16-bit reload", a_cnt(1), 32'h0000_FFFD);
    wr(a_run(1), 32'h2);
    wr(8'hFC, 32'h4);
    wr(a_ctl(1), 32'h12);
    wr(a_rld(1), 32'h0000_FFFE);
    wr(a_run(1), 32'h5);
    expect_rd("R3 control readback", a_ctl(1), 32'h13);
    edges(2);
    expect_rd("R6 32-bit passes 0xFFFF", a_cnt(1), 32'h0001_0000);
    expect_rd("R6 32-bit no event", 8'hF8, 32'd0);
    wr(a_rld(1), 32'hFFFF_FFFE);
    wr(a_run(1), 32'h5);
    edges(1);
    expect_rd("R6 32-bit top", a_cnt(1), 32'hFFFF_FFFF);
    edges(1);
    expect_rd("R6 32-bit event", 8'hF8, 32'h4);
    expect_rd("R6 32-bit reload", a_cnt(1), 32'hFFFF_FFFE);
    wr(a_run(1), 32'h2);
    wr(8'hFC, 32'h4);
  endtask

  task automatic t_oneshot;
    wr(a_ctl(2), 32'h9);
    expect_rd("R3 bit0 ignores writes", a_ctl(2), 32'h8);
    wr(a_rld(2), 32'd3);
    wr(a_run(2), 32'h5);
    edges(2);
    expect_rd("R7 count", a_cnt(2), 32'd1);
    expect_rd("R7 running", a_ctl(2), 32'h9);
    edges(1);
    expect_rd("R7 event bit4", 8'hF8, 32'h10);
    expect_rd("R7 halted", a_ctl(2), 32'h8);
    edges(3);
    expect_rd("R7 count parked at reload", a_cnt(2), 32'd3);
    wr(8'hFC, 32'h10);
    wr(a_run(2), 32'h3);
    expect_rd("R4 stop beats start idle", a_ctl(2), 32'h8);
    wr(a_run(2), 32'h1);
    expect_rd("R4 start only", a_ctl(2), 32'h9);
    wr(a_run(2), 32'h3);
    expect_rd("R4 stop beats start running", a_ctl(2), 32'h8);
    expect_rd("R4 start keeps count", a_cnt(2), 32'd2);
  endtask

  task automatic t_freeze;
    wr(a_ctl(0), 32'h0);
    wr(a_rld(0), 32'd100);
    wr(a_run(0), 32'h5);
    wr(8'h00, 32'hFFFF_FFFF);
    expect_rd("R11 clock-control bits", 8'h00, 32'h0001_0111);
    expect_rd("R11 count at freeze", a_cnt(0), 32'd99);
    edges(10);
    expect_rd("R11 frozen count", a_cnt(0), 32'd99);
    expect_rd("R11 still running flag", a_ctl(0), 32'h1);
    wr(8'h00, 32'h0);
    expect_rd("R11 still frozen on release edge", a_cnt(0), 32'd99);
    edges(1);
    expect_rd("R11 resumed", a_cnt(0), 32'd98);
    expect_rd("R11 no event", 8'hF8, 32'd0);
    wr(a_run(0), 32'h2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_down_continuous();
    t_irq();
    t_up();
    t_oneshot();
    t_freeze();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule